// File: doc/BRIEF.md
# MII Management Bus Master

This block lets a processor read and write the registers of Ethernet PHYs over the two-wire management bus. Software sees six small registers on a simple select/write-enable bus. It loads a combined PHY/register address. It then starts a transfer in one of two ways: a write begins as soon as a value is stored in the write-data register, and a read begins when the read bit of the command register goes from 0 to 1. The block divides the system clock down to the management clock and shifts out a complete Clause 22 frame. During a read it releases the data line and shifts in the PHY's reply.

Two status flags tell software when it may continue. The busy flag covers the whole frame. The not-valid flag stays high from the start of a read until the reply has been stored in the read-data register. A management-reset bit in the configuration register stops any frame in progress, clears both flags and holds the engine idle. The clock-select field sets the divide ratio. Value 9 gives a divide-by-40 clock that stays at or below 2.5 MHz from a 100 MHz system clock.

Register selects: 0 configuration, 1 command, 2 address, 3 write data, 4 read data, 5 status. Any other select reads as zero.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `mdc` and `mdio_oe` are low. Status (select 5), address (select 2) and read data (select 4) read 0. Configuration (select 0) reads clock-select = 9 (bits 3:0) with the management-reset bit (bit 15) clear.
- R2: The address register (select 2) holds the PHY address in bits 12:8 and the register address in bits 4:0. All other bits read back as 0.
- R3: A write to select 3 while the engine is idle and not in management reset starts a write frame. The busy bit (status bit 0) reads 1 on the first cycle after that write. The accepted 16-bit value reads back from select 3.
- R4: A write frame has 64 bits, sent MSB first, with the data line driven (`mdio_oe` high) throughout. The bits are: 32 ones, then 01, then 01, then the PHY address, then the register address, then 10, then the 16 data bits. `mdio_out` changes only while `mdc` is low.
- R5: Writing 1 to command bit 0 when it held 0, with the engine idle and not in reset, starts a read frame. Busy and not-valid (status bit 1) both go high. The read frame is sent MSB first: 32 ones, then 01, then 10, then the PHY address, then the register address. `mdio_oe` is driven for those 46 bits and released for the remaining 18 (turnaround and data).
- R6: During the last 16 bits of a read, `mdio_in` is sampled on each rising `mdc`, MSB first. When the frame ends, those bits appear at select 4 and busy and not-valid clear together. Not-valid is never high without busy.
- R7: The `mdc` period is 4*(clock-select+1) system clocks, which gives 40 for clock-select 9. `mdc` stays low while no frame runs.
- R8: While the management-reset bit (configuration bit 15) is set, any frame in progress stops. Busy, not-valid, `mdc` and `mdio_oe` go low, and command or write-data writes start nothing.
- R9: While busy, a write to select 3 is discarded and a 0-to-1 write of the read bit starts nothing. Exactly one frame is sent.
- R10: The read bit is level-held. Writing 1 again while it already holds 1 starts no frame. Clearing it to 0 leaves the read data and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Register select |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read-back of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data, output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data, input value |

## Verification
The embedded properties check four things on every cycle:
- a frame start on an idle write is reflected in busy at once;
- the data line holds still while `mdc` is high;
- not-valid never outlives busy;
- management reset forces the outputs idle.

Other behaviours need whole frames and can only be shown by the bench's scenarios. These are the exact bit content of write and read frames, the point where the output enable is released, the capture of reply bits into the read-data register, the `mdc` period for several clock-select values, and the dropping of commands that arrive while busy or while the read bit is already held.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_BITS = 64;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam int ADR_W      = 5;
   localparam int DAT_W      = 16;
   localparam int TA_POS     = 46;   // first turnaround bit index
   localparam int DATA_POS   = 48;   // first data bit index

   typedef enum logic [2:0] {
      SEL_CFG  = 3'd0,
      SEL_CMD  = 3'd1,
      SEL_ADDR = 3'd2,
      SEL_WDAT = 3'd3,
      SEL_RDAT = 3'd4,
      SEL_STAT = 3'd5
   } reg_sel_e;

   function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic             rd,
      input logic [ADR_W-1:0] phy,
      input logic [ADR_W-1:0] ra,
      input logic [DAT_W-1:0] d);
      logic [1:0] op;
      logic [1:0] ta;
      logic [DAT_W-1:0] body;
      op   = rd ? 2'b10 : 2'b01;
      ta   = rd ? 2'b11 : 2'b10;
      body = rd ? {DAT_W{1'b1}} : d;
      return {32'hFFFF_FFFF, 2'b01, op, phy, ra, ta, body};
   endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int HALF_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HALF_W-1:0] half_m1,
   output logic              mdc,
   output logic              rise_tick,
   output logic              fall_tick
);
   logic [HALF_W-1:0] cnt_q;
   logic              mdc_q;
   logic              wrap;

   assign wrap      = run && (cnt_q == half_m1);
   assign rise_tick = wrap && !mdc_q;
   assign fall_tick = wrap && mdc_q;
   assign mdc       = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7: clock parked low whenever no frame runs
   p_mdc_low_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_pkg::*;
#(
   parameter bit IN_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic             start_wr,
   input  logic             start_rd,
   input  logic [ADR_W-1:0] phy,
   input  logic [ADR_W-1:0] ra,
   input  logic [DAT_W-1:0] wdat,
   input  logic             rise_tick,
   input  logic             fall_tick,
   input  logic             mdio_i,
   output logic             busy,
   output logic             mdio_o,
   output logic             mdio_oe,
   output logic             rd_done,
   output logic [DAT_W-1:0] rd_value
);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
   localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

   logic                  busy_q, rd_q, last_q;
   logic [FRAME_BITS-1:0] sh_q;
   logic [IDX_W-1:0]      idx_q;
   logic [DAT_W-1:0]      rx_q;
   logic                  mdio_s;

   generate
      if (IN_REG) begin : g_in_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mdio_s <= 1'b1;
            else        mdio_s <= mdio_i;
         end
      end else begin : g_in_direct
         assign mdio_s = mdio_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
         last_q <= 1'b0;
         sh_q   <= '1;
         idx_q  <= '0;
         rx_q   <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
         last_q <= 1'b0;
         idx_q  <= '0;
      end else if (!busy_q) begin
         if (start_wr || start_rd) begin
            busy_q <= 1'b1;
            rd_q   <= start_rd;
            last_q <= 1'b0;
            idx_q  <= '0;
            sh_q   <= build_frame(start_rd, phy, ra, wdat);
         end
      end else begin
         if (rise_tick) begin
            if (rd_q && idx_q >= DATA_IDX)
               rx_q <= {rx_q[DAT_W-2:0], mdio_s};
            if (idx_q == LAST_IDX)
               last_q <= 1'b1;
         end
         if (fall_tick) begin
            if (last_q) begin
               busy_q <= 1'b0;
            end else begin
               sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign busy     = busy_q;
   assign mdio_o   = sh_q[FRAME_BITS-1];
   assign mdio_oe  = busy_q && !(rd_q && idx_q >= TA_IDX);
   assign rd_done  = busy_q && !abort && fall_tick && last_q && rd_q;
   assign rd_value = rx_q;

   // R4: data line only moves on a falling management clock edge
   p_mdio_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(fall_tick)) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_pkg::*;
#(
   parameter int CLKSEL_W   = 4,
   parameter int DEF_CLKSEL = 9,
   parameter bit IN_REG     = 1'b1,
   parameter int BUS_W      = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bus_sel,
   input  logic             bus_we,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             mdc,
   output logic             mdio_out,
   output logic             mdio_oe,
   input  logic             mdio_in
);
   localparam int HALF_W  = CLKSEL_W + 1;
   localparam int MRST_B  = 15;
   localparam int PHY_LSB = 8;

   generate
      if (BUS_W < 16) begin : g_bad_bus
         $error("BUS_W must be at least 16");
      end
      if (CLKSEL_W < 1 || CLKSEL_W > 14) begin : g_bad_sel
         $error("CLKSEL_W must be in 1..14");
      end
      if (DEF_CLKSEL < 0 || DEF_CLKSEL >= (1 << CLKSEL_W)) begin : g_bad_def
         $error("DEF_CLKSEL does not fit CLKSEL_W");
      end
      if (BUS_W > 16) begin : g_hi_bits
         logic unused_hi;
         assign unused_hi = ^bus_wdata[BUS_W-1:16];
      end
   endgenerate

   logic                cfg_rst;
   logic [CLKSEL_W-1:0] cfg_sel;
   logic                cmd_rd;
   logic [ADR_W-1:0]    phy_q, ra_q;
   logic [DAT_W-1:0]    wdat_q, rdat_q;
   logic                nv_q;
   logic [HALF_W-1:0]   half_q;

   logic busy_w, rise_w, fall_w, done_w;
   logic [DAT_W-1:0] rx_w;
   logic wr_cfg, wr_cmd, wr_addr, wr_wdat;
   logic start_wr, start_rd;

   assign wr_cfg  = bus_we && (bus_sel == SEL_CFG);
   assign wr_cmd  = bus_we && (bus_sel == SEL_CMD);
   assign wr_addr = bus_we && (bus_sel == SEL_ADDR);
   assign wr_wdat = bus_we && (bus_sel == SEL_WDAT);

   assign start_wr = wr_wdat && !busy_w && !cfg_rst;
   assign start_rd = wr_cmd && bus_wdata[0] && !cmd_rd && !busy_w && !cfg_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rst <= 1'b0;
         cfg_sel <= CLKSEL_W'(DEF_CLKSEL);
         cmd_rd  <= 1'b0;
         phy_q   <= '0;
         ra_q    <= '0;
         wdat_q  <= '0;
         rdat_q  <= '0;
         nv_q    <= 1'b0;
         half_q  <= '1;
      end else begin
         if (wr_cfg) begin
            cfg_rst <= bus_wdata[MRST_B];
            cfg_sel <= bus_wdata[CLKSEL_W-1:0];
         end
         if (wr_cmd)
            cmd_rd <= bus_wdata[0];
         if (wr_addr) begin
            phy_q <= bus_wdata[PHY_LSB +: ADR_W];
            ra_q  <= bus_wdata[ADR_W-1:0];
         end
         if (start_wr)
            wdat_q <= bus_wdata[DAT_W-1:0];
         if (start_wr || start_rd)
            half_q <= {cfg_sel, 1'b1};
         if (done_w)
            rdat_q <= rx_w;
         if (cfg_rst)       nv_q <= 1'b0;
         else if (start_rd) nv_q <= 1'b1;
         else if (done_w)   nv_q <= 1'b0;
      end
   end

   mdio_clk_div #(.HALF_W(HALF_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy_w && !cfg_rst),
      .half_m1   (half_q),
      .mdc       (mdc),
      .rise_tick (rise_w),
      .fall_tick (fall_w)
   );

   mdio_frame_engine #(.IN_REG(IN_REG)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (cfg_rst),
      .start_wr  (start_wr),
      .start_rd  (start_rd),
      .phy       (phy_q),
      .ra        (ra_q),
      .wdat      (bus_wdata[DAT_W-1:0]),
      .rise_tick (rise_w),
      .fall_tick (fall_w),
      .mdio_i    (mdio_in),
      .busy      (busy_w),
      .mdio_o    (mdio_out),
      .mdio_oe   (mdio_oe),
      .rd_done   (done_w),
      .rd_value  (rx_w)
   );

   always_comb begin
      bus_rdata = '0;
      case (reg_sel_e'(bus_sel))
         SEL_CFG: begin
            bus_rdata[MRST_B]       = cfg_rst;
            bus_rdata[CLKSEL_W-1:0] = cfg_sel;
         end
         SEL_CMD:  bus_rdata[0] = cmd_rd;
         SEL_ADDR: begin
            bus_rdata[PHY_LSB +: ADR_W] = phy_q;
            bus_rdata[ADR_W-1:0]        = ra_q;
         end
         SEL_WDAT: bus_rdata[DAT_W-1:0] = wdat_q;
         SEL_RDAT: bus_rdata[DAT_W-1:0] = rdat_q;
         SEL_STAT: bus_rdata[1:0]       = {nv_q, busy_w};
         default:  bus_rdata = '0;
      endcase
   end

   // R3: idle write of the data register raises busy on the next cycle
   p_busy_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_sel == SEL_WDAT && !busy_w && !cfg_rst) |=> busy_w);

   // R8: management reset forces everything idle
   p_mreset_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rst |=> (!busy_w && !nv_q && !mdc && !mdio_oe));

   // R6: not-valid never outlives the frame
   p_nv_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      nv_q |-> busy_w);

   // R6: not-valid falls together with busy
   p_nv_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nv_q) |-> $fell(busy_w));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
   import mdio_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 4;
   // {read, phy, reg, data/reply, clksel}
   localparam logic [30:0] VEC [NVEC] = '{
      {1'b0, 5'd1,  5'd0,  16'hA5C3, 4'd0},
      {1'b1, 5'd31, 5'd31, 16'h8001, 4'd0},
      {1'b0, 5'd0,  5'd31, 16'h0000, 4'd1},
      {1'b1, 5'd10, 5'd5,  16'h5AF0, 4'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_sel = 3'd0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_out, mdio_oe;
   logic        mdio_in = 1'b1;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   logic [63:0] cap_frame, cap_oe;
   logic [15:0] resp_word;
   int          rise_cnt;
   time         t_r0, t_r1;
   int          glitch;
   logic        prev_mdc = 1'b0, prev_out = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_mgmt_master u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
   );

   // PHY responder and frame capture
   always @(posedge mdc) begin
      cap_frame = {cap_frame[62:0], mdio_out};
      cap_oe    = {cap_oe[62:0], mdio_oe};
      if (rise_cnt == 0) t_r0 = $time;
      if (rise_cnt == 1) t_r1 = $time;
      rise_cnt++;
   end

   always @(negedge mdc) begin
      if (rise_cnt >= 48 && rise_cnt < 64) mdio_in = resp_word[63 - rise_cnt];
      else                                 mdio_in = 1'b1;
   end

   always @(negedge clk) begin
      if (prev_mdc && mdc && mdio_oe && (mdio_out !== prev_out)) glitch++;
      prev_mdc = mdc;
      prev_out = mdio_out;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      bus_sel = s; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [31:0] d);
      @(negedge clk);
      bus_sel = s;
      #1 d = bus_rdata;
   endtask

   task automatic arm(input logic [15:0] r);
      rise_cnt = 0; cap_frame = '0; cap_oe = '0; resp_word = r; glitch = 0;
      t_r0 = 0; t_r1 = 0;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] st;
      int n = 0;
      rd(SEL_STAT, st);
      while (st[0] && n < 4000) begin
         rd(SEL_STAT, st);
         n++;
      end
      if (st[0]) check(req, 64'(st[0]), 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] st;
      logic        vrd;
      logic [4:0]  vphy, vreg;
      logic [15:0] vdat;
      logic [3:0]  vsel;
      arm(16'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(SEL_STAT, st); check("R1 status", 64'(st), 64'd0);
      rd(SEL_CFG, st);  check("R1 config", 64'(st), 64'd9);
      rd(SEL_ADDR, st); check("R1 address", 64'(st), 64'd0);
      rd(SEL_RDAT, st); check("R1 read data", 64'(st), 64'd0);
      check("R1 mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);

      // R2: address field layout
      wr(SEL_ADDR, 32'hFFFF_FFFF);
      rd(SEL_ADDR, st); check("R2 address fields", 64'(st), 64'h1F1F);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         {vrd, vphy, vreg, vdat, vsel} = VEC[v];
         wr(SEL_CFG, 32'(vsel));
         wr(SEL_ADDR, 32'({vphy, 3'b000, vreg}));
         arm(vdat);
         if (vrd) begin
            wr(SEL_CMD, 32'd0);
            wr(SEL_CMD, 32'd1);
            rd(SEL_STAT, st); check("R5 busy+notvalid", 64'(st[1:0]), 64'd3);
         end else begin
            wr(SEL_WDAT, 32'(vdat));
            rd(SEL_STAT, st); check("R3 busy", 64'(st[1:0]), 64'd1);
         end
         wait_idle("R4 frame end");
         check("R7 mdc period", 64'((t_r1 - t_r0) / CLK_PERIOD), 64'(4 * (vsel + 1)));
         check("R4 bit count", 64'(rise_cnt), 64'd64);
         check("R4 mdio moves on fall only", 64'(glitch), 64'd0);
         check("R7 mdc idle low", 64'(mdc), 64'd0);
         if (vrd) begin
            check("R5 read header", 64'(cap_frame[63:18]),
                  64'({32'hFFFF_FFFF, 2'b01, 2'b10, vphy, vreg}));
            check("R5 oe release", cap_oe, {{46{1'b1}}, 18'd0});
            rd(SEL_RDAT, st); check("R6 read data", 64'(st), 64'(vdat));
            rd(SEL_STAT, st); check("R6 flags clear", 64'(st), 64'd0);
         end else begin
            check("R4 write frame", cap_frame,
                  {32'hFFFF_FFFF, 2'b01, 2'b01, vphy, vreg, 2'b10, vdat});
            check("R4 oe driven", cap_oe, '1);
            rd(SEL_WDAT, st); check("R3 data readback", 64'(st), 64'(vdat));
         end
      end
      wr(SEL_CMD, 32'd0);

      // R9: commands while busy are dropped
      wr(SEL_CFG, 32'd0);
      wr(SEL_ADDR, 32'h0203);
      arm(16'h0);
      wr(SEL_WDAT, 32'h1234);
      wr(SEL_WDAT, 32'h5678);
      wr(SEL_CMD, 32'd1);
      wait_idle("R9 frame end");
      repeat (20) @(negedge clk);
      rd(SEL_STAT, st); check("R9 no second frame", 64'(st), 64'd0);
      check("R9 single frame", 64'(rise_cnt), 64'd64);
      check("R9 first data kept", 64'(cap_frame[15:0]), 64'h1234);
      rd(SEL_WDAT, st); check("R9 data readback", 64'(st), 64'h1234);

      // R10: level-held read bit
      wr(SEL_CMD, 32'd0);
      arm(16'hC00F);
      wr(SEL_CMD, 32'd1);
      wait_idle("R10 read end");
      rd(SEL_RDAT, st); check("R10 read data", 64'(st), 64'hC00F);
      wr(SEL_CMD, 32'd1);
      repeat (20) @(negedge clk);
      rd(SEL_STAT, st); check("R10 held bit no restart", 64'(st), 64'd0);
      check("R10 held bit frame count", 64'(rise_cnt), 64'd64);
      wr(SEL_CMD, 32'd0);
      rd(SEL_RDAT, st); check("R10 clear keeps data", 64'(st), 64'hC00F);
      rd(SEL_STAT, st); check("R10 clear keeps status", 64'(st), 64'd0);

      // R8: management reset
      arm(16'h0);
      wr(SEL_WDAT, 32'h0F0F);
      repeat (30) @(negedge clk);
      wr(SEL_CFG, 32'h8000);
      rd(SEL_STAT, st); check("R8 abort write", 64'(st), 64'd0);
      check("R8 mdc/oe idle", {62'd0, mdc, mdio_oe}, 64'd0);
      wr(SEL_WDAT, 32'h1111);
      wr(SEL_CMD, 32'd1);
      repeat (10) @(negedge clk);
      rd(SEL_STAT, st); check("R8 commands ignored", 64'(st), 64'd0);
      rd(SEL_WDAT, st); check("R8 data not taken", 64'(st), 64'h0F0F);
      wr(SEL_CMD, 32'd0);
      wr(SEL_CFG, 32'd0);
      wr(SEL_CMD, 32'd1);
      rd(SEL_STAT, st); check("R8 read started", 64'(st[1:0]), 64'd3);
      wr(SEL_CFG, 32'h8000);
      rd(SEL_STAT, st); check("R8 abort read clears not-valid", 64'(st), 64'd0);
      wr(SEL_CFG, 32'd0);
      wr(SEL_CMD, 32'd0);

      // R7: divide-by-40 setting
      wr(SEL_CFG, 32'd9);
      arm(16'h0);
      wr(SEL_WDAT, 32'hBEEF);
      wait_idle("R7 slow frame end");
      check("R7 div40 period", 64'((t_r1 - t_r0) / CLK_PERIOD), 64'd40);
      check("R7 slow frame data", 64'(cap_frame[15:0]), 64'hBEEF);
      check("R7 mdc idle low", 64'(mdc), 64'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule